// File: doc/BRIEF.md
# Level-Tracked Interrupt Delivery Engine

This engine sits between a bank of 24 interrupt input lines and a downstream interrupt controller. Each line does not carry a plain level. Instead, every line is driven by request events: assert, deassert and pulse. Each line keeps a small signed count of its outstanding asserts. A per-line routing entry holds a mask bit, a trigger mode (edge or level), an 8-bit vector, a 3-bit delivery mode, a physical/logical destination flag and an 8-bit destination. When a line becomes active, the engine issues one interrupt message that carries those routing fields and a level flag.

A level-triggered line that has been delivered is marked busy (remote IRR) and gets no further delivery until an end-of-interrupt naming its vector arrives. That end-of-interrupt re-arms every busy line with a matching vector. Any re-armed line whose count is still positive is delivered again at once. Rewriting a routing entry also re-evaluates the line. Pending lines are issued one per cycle, lowest line number first, through a single output slot with a valid/ready handshake.

Top module: `lvl_irq_engine`

## Requirements
- R1: After reset no message is pending, every routing entry is masked, all counts are zero, and `req_err` and `cnt_err` are low. An assert on a line still in its reset state produces no message.
- R2: On `req_op` 0 (assert), the line's count rises by one. A rise from exactly 0 to 1 on an unmasked line produces one message carrying that line's vector, delivery mode, destination flag, destination and trigger mode (`msg_level` 1 = level). A rise from 1 to 2 produces nothing.
- R3: On `req_op` 1 (deassert), the count falls by one and never produces a message. After the count is back at zero, a new assert delivers again.
- R4: On `req_op` 2 (pulse), the request acts as an assert immediately followed by a deassert. From a count of zero it delivers once and leaves the count at zero. `req_op` 3 does nothing.
- R5: `cnt_err[p]` is high exactly while line p's count is negative. A count that returns to zero from below produces no message.
- R6: A line whose entry has the mask bit set drops its deliveries without any message.
- R7: Issuing a level-triggered message sets that line's remote IRR. While the flag is set, no new 0→1 rise of that line delivers. An end-of-interrupt whose vector differs leaves the flag set.
- R8: An end-of-interrupt with vector V clears remote IRR on every line whose flag is set and whose vector is V. Each such line that is unmasked and has a positive count is delivered again. A cleared line with a zero count delivers on its next 0→1 rise.
- R9: A write of line p's entry delivers line p when the new entry is unmasked, remote IRR is clear and the count is positive. A write made while remote IRR is set delivers nothing.
- R10: A request naming line 24 or above changes nothing, and `req_err` is high in the cycle after it. Otherwise `req_err` is low.
- R11: Lines that need delivery are issued lowest number first, one message per cycle. While `msg_valid` is high and `msg_ready` is low, the message stays unchanged.
- R12: Counts saturate at +7 and -8. After nine asserts and seven deasserts the count is zero, so the next assert delivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request strobe |
| req_op | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 none |
| req_pin | input | 5 | Line number of the request |
| req_err | output | 1 | Request in the previous cycle named a line out of range |
| wr_valid | input | 1 | Routing entry write strobe |
| wr_pin | input | 5 | Line whose entry is written |
| wr_mask | input | 1 | New mask bit |
| wr_level | input | 1 | New trigger mode, 1 = level |
| wr_vec | input | 8 | New vector |
| wr_dmode | input | 3 | New delivery mode |
| wr_logical | input | 1 | New destination flag, 1 = logical |
| wr_dest | input | 8 | New destination |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_pin | output | 5 | Source line of the message |
| msg_vec | output | 8 | Vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination flag |
| msg_level | output | 1 | Level flag |
| msg_dest | output | 8 | Destination |
| cnt_err | output | 24 | Per-line negative-count flag |

## Verification
A corrupted count does not show at once. It shows only at the next 0→1 rise, which then either fails to deliver or delivers out of turn. For that reason the saturation and negative-count cases are driven across long runs of asserts and deasserts. A stuck or lost remote IRR flag shows at the next end-of-interrupt or entry write, as a missing or extra message two cycles later. The pending vector and the output slot show up within two cycles of any trigger, as a wrong `msg_pin` order or a message that changes while it is stalled.

// File: rtl/lvl_irq_engine.sv
`timescale 1ns/1ps
module lvl_irq_engine #(
  parameter int NPIN = 24,
  parameter int CW   = 4,
  parameter int VW   = 8,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NPIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [PW-1:0] req_pin,
  output logic          req_err,
  input  logic          wr_valid,
  input  logic [PW-1:0] wr_pin,
  input  logic          wr_mask,
  input  logic          wr_level,
  input  logic [VW-1:0] wr_vec,
  input  logic [2:0]    wr_dmode,
  input  logic          wr_logical,
  input  logic [DW-1:0] wr_dest,
  input  logic          eoi_valid,
  input  logic [VW-1:0] eoi_vec,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [PW-1:0] msg_pin,
  output logic [VW-1:0] msg_vec,
  output logic [2:0]    msg_dmode,
  output logic          msg_logical,
  output logic          msg_level,
  output logic [DW-1:0] msg_dest,
  output logic [NPIN-1:0] cnt_err
);
  localparam logic [1:0] OP_ASSERT   = 2'd0;
  localparam logic [1:0] OP_DEASSERT = 2'd1;
  localparam logic [1:0] OP_PULSE    = 2'd2;
  localparam int CMAX = (1 << (CW-1)) - 1;
  localparam int CMIN = -(1 << (CW-1));

  logic signed [CW-1:0] cnt_q [NPIN];
  logic signed [CW-1:0] cnt_n [NPIN];
  logic [VW-1:0] vec_q [NPIN];
  logic [VW-1:0] vec_n [NPIN];
  logic [2:0]    dm_q  [NPIN];
  logic [2:0]    dm_n  [NPIN];
  logic [DW-1:0] dst_q [NPIN];
  logic [DW-1:0] dst_n [NPIN];
  logic [NPIN-1:0] mask_q, mask_n, lvl_q, lvl_n, log_q, log_n;
  logic [NPIN-1:0] rirr_q, rirr_n, pend_q, pend_n;

  logic [PW-1:0] sel;
  logic          ld;
  logic          req_in, req_act, wr_in;
  logic signed [CW-1:0] c_old, c_mid, c_new;
  logic          trig;

  function automatic logic signed [CW-1:0] sat_step(input logic signed [CW-1:0] a,
                                                     input logic up);
    int s;
    s = int'(a) + (up ? 1 : -1);
    if (s > CMAX) s = CMAX;
    if (s < CMIN) s = CMIN;
    return CW'(s);
  endfunction

  assign req_in  = req_valid && (int'(req_pin) < NPIN);
  assign req_act = req_in && (req_op != 2'd3);
  assign wr_in   = wr_valid && (int'(wr_pin) < NPIN);

  always_comb begin
    sel = '0;
    for (int i = NPIN-1; i >= 0; i--)
      if (pend_q[i]) sel = PW'(i);
  end

  assign ld = (|pend_q) && (!msg_valid || msg_ready);

  always_comb begin
    cnt_n  = cnt_q;
    vec_n  = vec_q;
    dm_n   = dm_q;
    dst_n  = dst_q;
    mask_n = mask_q;
    lvl_n  = lvl_q;
    log_n  = log_q;
    rirr_n = rirr_q;
    pend_n = pend_q;
    c_old  = '0;
    c_mid  = '0;
    c_new  = '0;
    trig   = 1'b0;

    if (ld) begin
      pend_n[sel] = 1'b0;
      if (lvl_q[sel]) rirr_n[sel] = 1'b1;
    end

    if (eoi_valid)
      for (int i = 0; i < NPIN; i++)
        if (rirr_n[i] && vec_q[i] == eoi_vec) begin
          rirr_n[i] = 1'b0;
          if (cnt_q[i] > 0 && !mask_q[i]) pend_n[i] = 1'b1;
        end

    if (req_act) begin
      c_old = cnt_q[req_pin];
      c_mid = (req_op == OP_DEASSERT) ? c_old : sat_step(c_old, 1'b1);
      c_new = (req_op == OP_ASSERT)   ? c_mid : sat_step(c_mid, 1'b0);
      trig  = (req_op == OP_ASSERT || req_op == OP_PULSE) && c_old == 0 && c_mid == 1;
      if (trig && !mask_q[req_pin] && !(lvl_q[req_pin] && rirr_n[req_pin]))
        pend_n[req_pin] = 1'b1;
      cnt_n[req_pin] = c_new;
    end

    if (wr_in) begin
      mask_n[wr_pin] = wr_mask;
      lvl_n[wr_pin]  = wr_level;
      log_n[wr_pin]  = wr_logical;
      vec_n[wr_pin]  = wr_vec;
      dm_n[wr_pin]   = wr_dmode;
      dst_n[wr_pin]  = wr_dest;
      pend_n[wr_pin] = !wr_mask && !rirr_n[wr_pin] && cnt_n[wr_pin] > 0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIN; i++) begin
        cnt_q[i] <= '0;
        vec_q[i] <= '0;
        dm_q[i]  <= '0;
        dst_q[i] <= '0;
      end
      mask_q <= '1;
      lvl_q  <= '0;
      log_q  <= '0;
      rirr_q <= '0;
      pend_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      vec_q  <= vec_n;
      dm_q   <= dm_n;
      dst_q  <= dst_n;
      mask_q <= mask_n;
      lvl_q  <= lvl_n;
      log_q  <= log_n;
      rirr_q <= rirr_n;
      pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid   <= 1'b0;
      msg_pin     <= '0;
      msg_vec     <= '0;
      msg_dmode   <= '0;
      msg_logical <= 1'b0;
      msg_level   <= 1'b0;
      msg_dest    <= '0;
      req_err     <= 1'b0;
    end else begin
      req_err <= req_valid && !req_in;
      if (ld) begin
        msg_valid   <= 1'b1;
        msg_pin     <= sel;
        msg_vec     <= vec_q[sel];
        msg_dmode   <= dm_q[sel];
        msg_logical <= log_q[sel];
        msg_level   <= lvl_q[sel];
        msg_dest    <= dst_q[sel];
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_err
    assign cnt_err[g] = cnt_q[g][CW-1];
  end

endmodule

// File: rtl/lvl_irq_engine_chk.sv
`timescale 1ns/1ps
module lvl_irq_engine_chk #(
  parameter int NPIN = 24,
  parameter int CW   = 4,
  parameter int VW   = 8,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NPIN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic [PW-1:0] req_pin,
  input logic          req_err,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [PW-1:0] msg_pin,
  input logic [VW-1:0] msg_vec,
  input logic [DW-1:0] msg_dest,
  input logic          msg_level,
  input logic [NPIN-1:0] pend,
  input logic signed [CW-1:0] cnt [NPIN]
);
  localparam int CMAX = (1 << (CW-1)) - 1;
  localparam int CMIN = -(1 << (CW-1));

  a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && int'(req_pin) >= NPIN |=> req_err);

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !req_err);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_pin) && $stable(msg_vec)
                                 && $stable(msg_dest) && $stable(msg_level));

  a_r11_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(pend != '0));

  a_r11_pin_range: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> int'(msg_pin) < NPIN);

  for (genvar p = 0; p < NPIN; p++) begin : g_sat
    a_r12_top: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_op == 2'd0 && req_pin == PW'(p) && int'(cnt[p]) == CMAX
      |=> int'(cnt[p]) == CMAX);
    a_r12_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_op == 2'd1 && req_pin == PW'(p) && int'(cnt[p]) == CMIN
      |=> int'(cnt[p]) == CMIN);
  end
endmodule

bind lvl_irq_engine lvl_irq_engine_chk #(.NPIN(NPIN), .CW(CW), .VW(VW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_pin(req_pin),
  .req_err(req_err), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin),
  .msg_vec(msg_vec), .msg_dest(msg_dest), .msg_level(msg_level), .pend(pend_q), .cnt(cnt_q)
);

// File: tb/lvl_irq_engine_bench.sv
`timescale 1ns/1ps
module lvl_irq_engine_bench;
  localparam int NPIN = 24;
  localparam int PW = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0; logic [1:0] req_op = 0; logic [PW-1:0] req_pin = 0;
  logic wr_valid = 0; logic [PW-1:0] wr_pin = 0; logic wr_mask = 0, wr_level = 0, wr_logical = 0;
  logic [7:0] wr_vec = 0, wr_dest = 0; logic [2:0] wr_dmode = 0;
  logic eoi_valid = 0; logic [7:0] eoi_vec = 0;
  logic msg_ready = 1;
  logic req_err, msg_valid, msg_logical, msg_level;
  logic [PW-1:0] msg_pin; logic [7:0] msg_vec, msg_dest; logic [2:0] msg_dmode;
  logic [NPIN-1:0] cnt_err;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lvl_irq_engine u_lvl_irq_engine (
    .clk, .rst_n, .req_valid, .req_op, .req_pin, .req_err, .wr_valid, .wr_pin,
    .wr_mask, .wr_level, .wr_vec, .wr_dmode, .wr_logical, .wr_dest, .eoi_valid,
    .eoi_vec, .msg_valid, .msg_ready, .msg_pin, .msg_vec, .msg_dmode, .msg_logical,
    .msg_level, .msg_dest, .cnt_err);

  // reference model
  int mcnt [NPIN];
  bit mmask [NPIN], mlvl [NPIN], mlog [NPIN], mrirr [NPIN], mpend [NPIN];
  logic [7:0] mvec [NPIN], mdest [NPIN]; logic [2:0] mdm [NPIN];
  bit sv, slog, slvl, merr; int spin; logic [7:0] svec, sdest; logic [2:0] sdm;

  function automatic int sat(int v);
    if (v > 7) return 7;
    if (v < -8) return -8;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int sel = -1;
    for (int i = NPIN-1; i >= 0; i--) if (mpend[i]) sel = i;
    if (sel >= 0 && (!sv || msg_ready)) begin
      sv = 1; spin = sel; svec = mvec[sel]; sdm = mdm[sel]; slog = mlog[sel];
      slvl = mlvl[sel]; sdest = mdest[sel]; mpend[sel] = 0;
      if (mlvl[sel]) mrirr[sel] = 1;
    end else if (msg_ready) sv = 0;
    merr = req_valid && int'(req_pin) >= NPIN;
    if (eoi_valid)
      for (int i = 0; i < NPIN; i++)
        if (mrirr[i] && mvec[i] == eoi_vec) begin
          mrirr[i] = 0;
          if (mcnt[i] > 0 && !mmask[i]) mpend[i] = 1;
        end
    if (req_valid && int'(req_pin) < NPIN && req_op != 2'd3) begin
      int p = int'(req_pin);
      int o = mcnt[p];
      int m = (req_op == 2'd1) ? o : sat(o + 1);
      int n = (req_op == 2'd0) ? m : sat(m - 1);
      if (req_op != 2'd1 && o == 0 && m == 1 && !mmask[p] && !(mlvl[p] && mrirr[p]))
        mpend[p] = 1;
      mcnt[p] = n;
    end
    if (wr_valid && int'(wr_pin) < NPIN) begin
      int w = int'(wr_pin);
      mmask[w] = wr_mask; mlvl[w] = wr_level; mlog[w] = wr_logical;
      mvec[w] = wr_vec; mdm[w] = wr_dmode; mdest[w] = wr_dest;
      mpend[w] = !wr_mask && !mrirr[w] && mcnt[w] > 0;
    end
  endtask

  task automatic compare();
    logic [NPIN-1:0] e;
    chk(msg_valid === sv, "R11 msg_valid", 64'(msg_valid), 64'(sv));
    if (sv && msg_valid)
      chk({msg_pin, msg_vec, msg_dmode, msg_logical, msg_level, msg_dest} ===
          {PW'(spin), svec, sdm, slog, slvl, sdest}, "R2 message fields",
          64'({msg_pin, msg_vec, msg_dmode, msg_logical, msg_level, msg_dest}),
          64'({PW'(spin), svec, sdm, slog, slvl, sdest}));
    chk(req_err === merr, "R10 req_err", 64'(req_err), 64'(merr));
    for (int i = 0; i < NPIN; i++) e[i] = mcnt[i] < 0;
    chk(cnt_err === e, "R5 cnt_err", 64'(cnt_err), 64'(e));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    req_valid = 0; wr_valid = 0; eoi_valid = 0;
  endtask

  task automatic do_req(logic [1:0] op, int pin);
    req_valid = 1; req_op = op; req_pin = PW'(pin); cyc();
  endtask

  task automatic do_eoi(logic [7:0] v);
    eoi_valid = 1; eoi_vec = v; cyc();
  endtask

  task automatic do_wr(int pin, bit mk, bit lv, logic [7:0] v, logic [2:0] dm, bit lg, logic [7:0] d);
    wr_valid = 1; wr_pin = PW'(pin); wr_mask = mk; wr_level = lv; wr_vec = v;
    wr_dmode = dm; wr_logical = lg; wr_dest = d; cyc();
  endtask

  task automatic wait_msg(string tag, int pin, logic [7:0] v, bit lv);
    bit found = 0;
    for (int k = 0; k < 4 && !found; k++) begin
      if (msg_valid && msg_pin == PW'(pin)) begin
        found = 1;
        chk(msg_vec == v && msg_level == lv, tag, 64'({msg_vec, msg_level}), 64'({v, lv}));
      end
      cyc();
    end
    chk(found, tag, 64'(msg_pin), 64'(pin));
  endtask

  task automatic quiet(string tag, int n);
    bit bad = 0;
    for (int k = 0; k < n; k++) begin
      cyc();
      if (msg_valid) bad = 1;
    end
    chk(!bad, tag, 64'(bad), 64'(0));
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL R11 watchdog expired actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NPIN; i++) begin
      mcnt[i] = 0; mmask[i] = 1; mlvl[i] = 0; mlog[i] = 0; mrirr[i] = 0; mpend[i] = 0;
      mvec[i] = 0; mdest[i] = 0; mdm[i] = 0;
    end
    sv = 0; merr = 0; spin = 0; svec = 0; sdest = 0; sdm = 0; slog = 0; slvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!msg_valid && !req_err && cnt_err == '0, "R1 reset state",
        64'({msg_valid, req_err, cnt_err}), 64'(0));
    do_req(2'd0, 0);
    quiet("R1 reset entry masked", 4);
    do_req(2'd1, 0);

    do_wr(3, 0, 0, 8'h41, 3'd1, 1, 8'h12);
    do_req(2'd0, 3);
    wait_msg("R2 first assert", 3, 8'h41, 0);
    do_req(2'd0, 3);
    quiet("R2 second assert", 4);

    do_req(2'd1, 3);
    do_req(2'd1, 3);
    quiet("R3 deassert silent", 3);
    chk(cnt_err[3] == 0, "R3 count at zero", 64'(cnt_err[3]), 64'(0));
    do_req(2'd0, 3);
    wait_msg("R3 re-assert", 3, 8'h41, 0);
    do_req(2'd1, 3);

    do_wr(4, 0, 0, 8'h42, 3'd0, 0, 8'h01);
    do_req(2'd2, 4);
    wait_msg("R4 pulse", 4, 8'h42, 0);
    do_req(2'd0, 4);
    wait_msg("R4 count back at zero", 4, 8'h42, 0);
    do_req(2'd1, 4);
    do_req(2'd3, 4);
    quiet("R4 op 3 no effect", 3);

    do_wr(5, 0, 0, 8'h43, 3'd0, 0, 8'h02);
    do_req(2'd1, 5);
    chk(cnt_err[5] == 1, "R5 negative flag", 64'(cnt_err[5]), 64'(1));
    quiet("R5 no delivery negative", 2);
    do_req(2'd0, 5);
    chk(cnt_err[5] == 0, "R5 flag clears", 64'(cnt_err[5]), 64'(0));
    quiet("R5 -1 to 0 silent", 3);

    do_wr(6, 1, 0, 8'h44, 3'd2, 0, 8'h03);
    do_req(2'd0, 6);
    quiet("R6 masked dropped", 4);
    do_wr(6, 0, 0, 8'h44, 3'd2, 0, 8'h03);
    wait_msg("R9 unmask delivers", 6, 8'h44, 0);

    do_wr(7, 0, 1, 8'h50, 3'd0, 0, 8'h04);
    do_req(2'd0, 7);
    wait_msg("R7 level delivery", 7, 8'h50, 1);
    do_req(2'd1, 7);
    do_req(2'd0, 7);
    quiet("R7 held by remote IRR", 4);
    do_eoi(8'h51);
    quiet("R7 other vector", 4);
    do_eoi(8'h50);
    wait_msg("R7 eoi redelivers", 7, 8'h50, 1);
    do_wr(7, 0, 1, 8'h50, 3'd0, 0, 8'h04);
    quiet("R9 write while remote IRR set", 4);

    do_wr(8, 0, 1, 8'h60, 3'd0, 0, 8'h05);
    do_wr(9, 0, 1, 8'h60, 3'd0, 0, 8'h06);
    do_req(2'd0, 8);
    wait_msg("R8 pin 8 first", 8, 8'h60, 1);
    do_req(2'd0, 9);
    wait_msg("R8 pin 9 first", 9, 8'h60, 1);
    do_req(2'd1, 9);
    do_eoi(8'h60);
    wait_msg("R8 shared eoi redelivers active", 8, 8'h60, 1);
    quiet("R8 idle pin not redelivered", 3);
    do_req(2'd0, 9);
    wait_msg("R8 idle pin re-armed", 9, 8'h60, 1);

    do_req(2'd0, 24);
    chk(req_err == 1, "R10 out of range", 64'(req_err), 64'(1));
    quiet("R10 no effect", 3);
    chk(req_err == 0, "R10 flag drops", 64'(req_err), 64'(0));

    do_wr(10, 0, 0, 8'h70, 3'd0, 0, 8'h0a);
    do_wr(11, 0, 0, 8'h71, 3'd0, 0, 8'h0b);
    do_wr(12, 0, 0, 8'h72, 3'd0, 0, 8'h0c);
    msg_ready = 0;
    do_req(2'd0, 12);
    do_req(2'd0, 10);
    do_req(2'd0, 11);
    cyc();
    chk(msg_valid && msg_pin == 12, "R11 stalled message held", 64'(msg_pin), 64'(12));
    msg_ready = 1;
    wait_msg("R11 order 12", 12, 8'h72, 0);
    wait_msg("R11 order 10", 10, 8'h70, 0);
    wait_msg("R11 order 11", 11, 8'h71, 0);

    do_wr(13, 0, 0, 8'h73, 3'd0, 0, 8'h0d);
    do_req(2'd0, 13);
    wait_msg("R12 first", 13, 8'h73, 0);
    for (int k = 0; k < 8; k++) do_req(2'd0, 13);
    for (int k = 0; k < 7; k++) do_req(2'd1, 13);
    quiet("R12 no delivery", 2);
    do_req(2'd0, 13);
    wait_msg("R12 saturated count", 13, 8'h73, 0);

    for (int n = 0; n < 3000; n++) begin
      int a = $urandom_range(0, 99);
      int p = ($urandom_range(0, 19) == 0) ? 26 : 14 + $urandom_range(0, 5);
      logic [7:0] v = 8'h80 + 8'($urandom_range(0, 2));
      msg_ready = ($urandom_range(0, 3) != 0);
      if (a < 45) begin
        req_valid = 1; req_op = 2'($urandom_range(0, 3)); req_pin = PW'(p);
      end else if (a < 60) begin
        eoi_valid = 1; eoi_vec = v;
      end else if (a < 75) begin
        wr_valid = 1; wr_pin = PW'(p); wr_mask = ($urandom_range(0, 3) == 0);
        wr_level = 1'($urandom_range(0, 1)); wr_vec = v; wr_dmode = 3'($urandom_range(0, 7));
        wr_logical = 1'($urandom_range(0, 1)); wr_dest = 8'($urandom_range(0, 255));
      end
      cyc();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule